// File: doc/BRIEF.md
# Instruction-Framed Serial Register Port

This block is a serial slave that lets a host reach a small bank of configuration registers, each with its own byte width. The host lowers chip select and clocks in one command byte, most significant bit first. That byte names a register and says whether the host will read it or write it. A data phase follows. The register's own width sets how many bytes the data phase carries. When the data phase ends, the port waits for another command byte, even if chip select stays low.

The serial pins are not clocked by the serial clock. The system clock samples them through two synchronizer stages. The block acts on rising serial-clock edges (to take in data) and on falling edges (to send data out). The serial clock may rest high or low between transfers.

A mode input selects where read data leaves the block. With the mode input high, read data goes out on a separate output pin and the data pin is ignored. With the mode input low, read data is driven back on the shared bidirectional data pin. Every register is also visible at all times on a flat parallel output bus.

Top module: `instr_serial_port`

## Requirements
- R1: The first eight rising serial-clock edges after chip select falls carry the command byte, MSB first. Bit 7 is the direction flag (1 = read, 0 = write). Bits 4:0 are the register address. Bits 6:5 have no effect.
- R2: A data phase lasts (a mod 4 + 1) bytes for a mapped address a below NUM_REGS. So address 0 takes 1 byte, address 1 takes 2, address 2 takes 3 and address 3 takes 4. Any other address takes 1 byte.
- R3: Write data is shifted in MSB first and stored in the register only after its last bit arrives. Register a appears zero-extended on bus bits [a*32 +: 32].
- R4: A read sends the register value MSB first. Each bit changes after a falling serial-clock edge and is valid at the following rising edge.
- R5: After the last data bit, the next eight rising edges form a new command byte, even if chip select stays low.
- R6: Raising chip select abandons any transaction in progress. A partly received write leaves the bank unchanged, and the next transfer begins with a command byte.
- R7: With three_wire = 1, read data leaves on sdo and whatever is on sdio during the read is ignored. sdo stays low outside a read data phase.
- R8: With three_wire = 0, read data is driven on sdio only during the read data phase while chip select is low. At all other times the block leaves sdio undriven.
- R9: A read of an unmapped address returns one zero byte. A write to an unmapped address changes no register.
- R10: Transfers work the same whether the serial clock rests low or high between them.
- R11: After reset, every register and sdo read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdio | inout | 1 | Serial data in; in two-wire mode it also carries read data |
| sdo | output | 1 | Read data output in three-wire mode |
| three_wire | input | 1 | 1 = read data on sdo, 0 = read data on sdio |
| bank | output | NUM_REGS*32 | All registers side by side, register a at [a*32 +: 32] |

## Verification
Each serial edge takes effect two system clocks after it happens, because of the synchronizer, plus one more clock for the register that acts on it.

A written value therefore reaches the bank three clocks after the final rising edge. The bench reads the bus only after it has raised chip select and waited several more clocks.

A read bit is valid about three clocks after the falling edge. The bench samples it at the moment it raises the serial clock, six clocks after the fall.

The bench holds the last command bit for two clocks after the rising edge, then releases sdio before the block starts to drive it.

// File: rtl/instr_serial_port.sv
module instr_serial_port #(
  parameter int NUM_REGS  = 4,
  parameter int MAX_BYTES = 4,
  parameter int ADDR_W    = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cs_n,
  input  logic                            sclk,
  inout  wire                             sdio,
  output logic                            sdo,
  input  logic                            three_wire,
  output logic [NUM_REGS*8*MAX_BYTES-1:0] bank
);
  localparam int DW = 8 * MAX_BYTES;
  localparam int CW = $clog2(DW + 1);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  function automatic logic [CW-1:0] bits_for(input logic [ADDR_W-1:0] a);
    if (int'(a) < NUM_REGS) return CW'((int'(a) % MAX_BYTES + 1) * 8);
    return CW'(8);
  endfunction

  logic [2:0] sclk_q;
  logic [1:0] cs_q, sdi_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= 2'b11;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      sdi_q  <= {sdi_q[0], sdio};
    end

  wire sel  = ~cs_q[1];
  wire rise = sel & sclk_q[1] & ~sclk_q[2];
  wire fall = sel & ~sclk_q[1] & sclk_q[2];
  wire din  = sdi_q[1];

  logic              data_ph, rd, dout;
  logic [ADDR_W-1:0] addr;
  logic [CW-1:0]     cnt, len;
  logic [DW-1:0]     rx, tx;
  logic [DW-1:0]     regs [NUM_REGS];

  wire [ADDR_W-1:0] ins_addr = {rx[ADDR_W-2:0], din};
  wire [CW-1:0]     ins_len  = bits_for(ins_addr);
  wire [DW-1:0]     rx_next  = {rx[DW-2:0], din};
  wire              last_dat = data_ph && (cnt == len - 1'b1);
  wire [DW-1:0]     rd_word  = (int'(ins_addr) < NUM_REGS) ? regs[ins_addr[IW-1:0]] : '0;
  wire [DW-1:0]     wr_mask  = {DW{1'b1}} >> (DW - int'(len));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_ph <= 1'b0;
      rd      <= 1'b0;
      cnt     <= '0;
      len     <= CW'(8);
      addr    <= '0;
      rx      <= '0;
      tx      <= '0;
      dout    <= 1'b0;
    end else if (!sel) begin
      data_ph <= 1'b0;
      rd      <= 1'b0;
      cnt     <= '0;
    end else begin
      if (rise) begin
        rx <= rx_next;
        if (!data_ph) begin
          if (cnt == CW'(7)) begin
            data_ph <= 1'b1;
            cnt     <= '0;
            rd      <= rx[6];
            addr    <= ins_addr;
            len     <= ins_len;
            tx      <= rd_word << (DW - int'(ins_len));
          end else cnt <= cnt + 1'b1;
        end else if (last_dat) begin
          data_ph <= 1'b0;
          cnt     <= '0;
        end else cnt <= cnt + 1'b1;
      end
      if (fall && data_ph && rd) begin
        dout <= tx[DW-1];
        tx   <= tx << 1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (sel && rise && last_dat && !rd && int'(addr) < NUM_REGS) begin
      regs[addr[IW-1:0]] <= rx_next & wr_mask;
    end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    assign bank[g*DW +: DW] = regs[g];
  end

  wire rd_live = sel & data_ph & rd;
  wire oe      = rd_live & ~three_wire;
  assign sdio  = oe ? dout : 1'bz;
  assign sdo   = (rd_live & three_wire) ? dout : 1'b0;

  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (!data_ph && cnt == '0));
  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    data_ph |-> (len != '0 && len <= CW'(DW) && len[2:0] == 3'd0));
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && cnt < len) || (!data_ph && cnt < CW'(8)));
  a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rise && last_dat) |=> (!data_ph && cnt == '0));
  a_r3_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank) |-> $past(sel && rise && last_dat && !rd));
  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && data_ph && rd) |=> (dout == $past(tx[DW-1])));
endmodule

// File: tb/test_instr_serial_port.sv
module test_instr_serial_port;
  localparam int HP = 6;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, three_wire = 0;
  logic host_oe = 0, host_bit = 0;
  wire  sdio;
  wire  sdo;
  wire [127:0] bank;
  int n_chk = 0, n_fail = 0;
  logic [31:0] model [4];
  logic idle_hi = 0;

  assign sdio = host_oe ? host_bit : 1'bz;
  always #5 clk = ~clk;

  instr_serial_port i_instr_serial_port (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sdio(sdio), .sdo(sdo), .three_wire(three_wire), .bank(bank));

  function automatic int nbytes(input logic [7:0] ins);
    int a = int'(ins[4:0]);
    return (a < 4) ? (a % 4 + 1) : 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] ins, input logic [31:0] wdata,
                      output logic [31:0] rdata, input bit keep_open);
    int nb = nbytes(ins);
    bit rdop = ins[7];
    rdata = 0;
    if (cs_n) begin cs_n = 0; waitn(3); end
    for (int i = 7; i >= 0; i--) begin
      sclk = 0; host_oe = 1; host_bit = ins[i]; waitn(HP);
      sclk = 1;
      if (i == 0 && rdop) begin waitn(2); host_oe = three_wire; waitn(HP - 2); end
      else waitn(HP);
    end
    for (int i = nb * 8 - 1; i >= 0; i--) begin
      sclk = 0;
      if (rdop) host_bit = 1'($urandom); else host_bit = wdata[i];
      waitn(HP);
      if (rdop) rdata[i] = three_wire ? sdo : sdio;
      sclk = 1; waitn(HP);
    end
    if (!idle_hi) begin sclk = 0; waitn(HP); end
    if (!keep_open) begin
      cs_n = 1; host_oe = 0; waitn(4); sclk = idle_hi;
    end
  endtask

  task automatic do_write(input logic [7:0] ins, input logic [31:0] d);
    logic [31:0] r;
    int a = int'(ins[4:0]);
    xfer({1'b0, ins[6:0]}, d, r, 0);
    if (a < 4) model[a] = d & (32'hFFFF_FFFF >> (32 - 8 * nbytes(ins)));
  endtask

  task automatic check_bank(input string req);
    for (int a = 0; a < 4; a++) check(req, bank[a*32 +: 32], model[a]);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    for (int a = 0; a < 4; a++) model[a] = 0;
    waitn(3); rst_n = 1; waitn(3);
    check("R11 reset bank lo", bank[63:0], 0);
    check("R11 reset bank hi", bank[127:64], 0);
    check("R11 reset sdo", {31'd0, sdo}, 0);

    three_wire = 1;
    do_write(8'h03, 32'hA1B2C3D4);
    check("R3 R2 four byte write", bank[96 +: 32], 32'hA1B2C3D4);
    three_wire = 0;
    xfer(8'h83, 0, r, 0); check("R4 R8 two-wire read", r, 32'hA1B2C3D4);

    idle_hi = 1; sclk = 1; waitn(4);
    do_write(8'h02, 32'h00_5A_6B_7C);
    check("R10 R2 idle-high three byte write", bank[64 +: 32], 32'h005A6B7C);
    three_wire = 1;
    xfer(8'h82, 0, r, 0); check("R7 R10 three-wire read ignores sdio", r, 32'h005A6B7C);
    idle_hi = 0; sclk = 0; waitn(4);

    do_write(8'h61, 32'h0000BEEF);
    check("R1 bits 6:5 ignored on write", bank[32 +: 32], 32'h0000BEEF);
    xfer(8'hE1, 0, r, 0); check("R1 bits 6:5 ignored on read", r, 32'h0000BEEF);

    xfer(8'h89, 0, r, 0); check("R9 unmapped read zero", r, 0);
    do_write(8'h14, 32'h000000FF); check_bank("R9 unmapped write ignored");

    xfer(8'h00, 32'h000000C3, r, 1); model[0] = 32'hC3;
    xfer(8'h83, 0, r, 0);
    check("R5 back-to-back read", r, 32'hA1B2C3D4);
    check("R5 back-to-back write", bank[31:0], 32'hC3);

    cs_n = 0; waitn(3);
    for (int i = 0; i < 20; i++) begin
      sclk = 0; host_oe = 1; host_bit = (i < 8) ? ((8'h03 >> (7 - i)) & 1) : 1'b1;
      waitn(HP); sclk = 1; waitn(HP);
    end
    sclk = 0; waitn(HP); cs_n = 1; host_oe = 0; waitn(5);
    check_bank("R6 aborted write not committed");
    xfer(8'h83, 0, r, 0); check("R6 next transfer starts with command", r, model[3]);

    for (int k = 0; k < 50; k++) begin
      logic [7:0] ins = 8'($urandom_range(0, 7)) | (8'($urandom_range(0, 3)) << 5);
      bit hi = 1'($urandom);
      three_wire = 1'($urandom);
      if (hi != idle_hi) begin idle_hi = hi; sclk = hi; waitn(4); end
      if ($urandom_range(0, 1) == 1) begin
        xfer(ins | 8'h80, 0, r, 0);
        check("R4 random read", r, (int'(ins[4:0]) < 4) ? model[ins[1:0]] : 32'h0);
      end else begin
        do_write(ins, $urandom);
        check_bank("R3 random write");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule